// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down and recovery for a small microcontroller core. When the core executes its sleep instruction, the block stops the oscillator driver, halts the core, and updates two status bits. The first (`pd_bit`) reports that power-down was entered. The second (`to_bit`) reports that no watchdog time-out has occurred. Every entry into sleep and every wake-up also produces a one-cycle watchdog clear pulse. The watchdog counter itself lives outside and keeps counting.

Three wake sources are watched while asleep: an external reset request, a watchdog time-out (honoured only when the watchdog is enabled), and any interrupt source whose flag and enable bits are both set. The global interrupt enable does not gate wake-up. It only chooses what happens once the core resumes: either it continues in-line, or it runs the next instruction, takes a dummy flush cycle and is redirected to the interrupt vector. In crystal oscillator modes the core is held for a start-up interval of 2^CNT_W clock periods after wake-up. In RC mode that interval is skipped. If an enabled interrupt is already pending when the sleep instruction executes, the sleep instruction completes but the device never actually goes to sleep.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, `pd_bit`=1, `to_bit`=1, `osc_enable`=1, `core_halt`=0, and `wdt_clear`, `dev_reset`, `dummy_cycle` and `redirect_valid` are all 0.
- R2: A `sleep_exec` strobe taken while running, with no enabled interrupt pending, produces the following on the next cycle: `pd_bit`=0, `to_bit`=1, `osc_enable`=0, `core_halt`=1, and `wdt_clear`=1 for exactly one cycle.
- R3: While asleep, `ext_reset_req` wakes the block. It produces a one-cycle `dev_reset` pulse together with `wdt_clear`, and leaves `pd_bit`=0 and `to_bit`=1. After start-up the core resumes with no redirect.
- R4: While asleep, `wdt_timeout` wakes the block only when `wdt_enable`=1, and that wake-up clears `to_bit` to 0. With `wdt_enable`=0 the time-out is ignored and `osc_enable` stays 0.
- R5: An interrupt wakes the block only when some bit i has both `int_flags[i]` and `int_enables[i]` set. A flag whose enable is clear does not wake it, and wake-up happens whatever the value of `glob_int_en`.
- R6: After an interrupt wake-up with `glob_int_en`=0 at the wake cycle, the core resumes with `dummy_cycle` and `redirect_valid` never asserted.
- R7: After an interrupt wake-up with `glob_int_en`=1, the sequence is: first one cycle with `core_halt`=0 and no redirect, which lets the next instruction execute; then one cycle with `dummy_cycle`=1, `redirect_valid`=1 and `redirect_addr`=0x0004; then normal running.
- R8: If an enabled interrupt is pending when `sleep_exec` is taken, the next cycle shows `pd_bit`=0, `to_bit`=1 and a `wdt_clear` pulse, while `osc_enable` stays 1 and `core_halt` stays 0. `glob_int_en` then picks the in-line or redirect path as in R6/R7.
- R9: In crystal mode (`osc_is_rc`=0), `core_halt` stays 1 and `osc_enable` stays 1 for exactly 2^CNT_W cycles (1024 by default), counted from the cycle after the wake event. In RC mode (`osc_is_rc`=1), `core_halt` is 0 on the cycle right after the wake event.
- R10: When several wake sources are present in the same cycle, the external reset takes priority over the watchdog, and the watchdog takes priority over an interrupt.
- R11: `sleep_exec` is ignored while asleep: no `wdt_clear` is produced and `osc_enable` stays 0.
- R12: `pd_bit` returns to 1 only through `rst_n`; no wake source sets it. Each new sleep entry sets `to_bit` back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sleep_exec | input | 1 | One-cycle strobe: sleep instruction executes |
| ext_reset_req | input | 1 | External reset request |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| wdt_enable | input | 1 | Watchdog enabled |
| int_flags | input | N_SRC | Per-source interrupt flags |
| int_enables | input | N_SRC | Per-source interrupt enables |
| glob_int_en | input | 1 | Global interrupt enable |
| osc_is_rc | input | 1 | 1 = RC oscillator mode, no start-up delay |
| osc_enable | output | 1 | Oscillator driver enable |
| core_halt | output | 1 | Core held |
| pd_bit | output | 1 | Power-down status bit (0 after sleep) |
| to_bit | output | 1 | Time-out status bit (0 after watchdog wake) |
| wdt_clear | output | 1 | One-cycle watchdog clear pulse |
| dev_reset | output | 1 | One-cycle device reset pulse on external-reset wake |
| redirect_valid | output | 1 | Redirect the fetch to `redirect_addr` |
| redirect_addr | output | ADDR_W | Interrupt vector address (0x0004) |
| dummy_cycle | output | 1 | Prefetched instruction is flushed this cycle |

## Verification
The wake path is tried one source at a time: external reset, watchdog with the enable on and with it off, an interrupt with its matching enable, and a flag whose enable is off. Together these separate the three causes through `dev_reset` and `to_bit`, and show that an unmatched flag leaves the block asleep. Each interrupt wake is run with the global enable both clear and set, which tells the in-line resume apart from the next-instruction, flush and vector sequence. Crystal and RC modes are contrasted by counting halted cycles. Finally, several sources are raised at once, and an interrupt is left pending at sleep entry, to tell apart the priority order and the immediate-wake path.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_SLEEP     = 3'd1,
    ST_STARTUP   = 3'd2,
    ST_EXEC_NEXT = 3'd3,
    ST_DUMMY     = 3'd4
  } swc_state_e;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_EXT  = 2'd1,
    WK_WDT  = 2'd2,
    WK_INT  = 2'd3
  } wake_src_e;

endpackage

// File: rtl/swc_wake_detect.sv
module swc_wake_detect
  import swc_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic             ext_reset_req,
  input  logic             wdt_timeout,
  input  logic             wdt_enable,
  input  logic [N_SRC-1:0] int_flags,
  input  logic [N_SRC-1:0] int_enables,
  output logic             int_pending,
  output wake_src_e        wake_src
);

  logic [N_SRC-1:0] src_hit;

  // each source must be both flagged and individually enabled
  for (genvar i = 0; i < N_SRC; i++) begin : g_hit
    assign src_hit[i] = int_flags[i] & int_enables[i];
  end

  assign int_pending = |src_hit;

  // fixed priority: external reset, then watchdog, then interrupt
  always_comb begin
    if (ext_reset_req)                  wake_src = WK_EXT;
    else if (wdt_timeout && wdt_enable) wake_src = WK_WDT;
    else if (int_pending)               wake_src = WK_INT;
    else                                wake_src = WK_NONE;
  end

endmodule

// File: rtl/swc_startup_timer.sv
module swc_startup_timer #(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);

  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load | run;

  always_comb begin
    if (load) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == CNT_LAST);

  // R9
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!done || CNT_W == 0));

endmodule

// File: rtl/swc_seq.sv
module swc_seq
  import swc_pkg::*;
#(
  parameter int          ADDR_W   = 13,
  parameter logic [31:0] VEC_ADDR = 32'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_exec,
  input  wake_src_e         wake_src,
  input  logic              int_pending,
  input  logic              glob_int_en,
  input  logic              osc_is_rc,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic              tmr_run,
  output logic              osc_enable,
  output logic              core_halt,
  output logic              pd_bit,
  output logic              to_bit,
  output logic              wdt_clear,
  output logic              dev_reset,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic              dummy_cycle
);

  localparam logic [ADDR_W-1:0] VEC = VEC_ADDR[ADDR_W-1:0];

  swc_state_e st_q, st_d;
  logic       pd_q, pd_d;
  logic       to_q, to_d;
  logic       vec_q, vec_d;
  logic       clr_q, clr_d;
  logic       rsp_q, rsp_d;
  swc_state_e wake_tgt;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    pd_d     = pd_q;
    to_d     = to_q;
    vec_d    = vec_q;
    clr_d    = 1'b0;
    rsp_d    = 1'b0;
    tmr_load = 1'b0;
    wake_tgt = ST_RUN;
    case (st_q)
      ST_RUN: begin
        if (sleep_exec) begin
          pd_d  = 1'b0;
          to_d  = 1'b1;
          clr_d = 1'b1;
          if (int_pending) st_d = glob_int_en ? ST_EXEC_NEXT : ST_RUN;
          else             st_d = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (wake_src != WK_NONE) begin
          clr_d    = 1'b1;
          vec_d    = (wake_src == WK_INT) && glob_int_en;
          rsp_d    = (wake_src == WK_EXT);
          if (wake_src == WK_WDT) to_d = 1'b0;
          wake_tgt = vec_d ? ST_EXEC_NEXT : ST_RUN;
          if (osc_is_rc) begin
            st_d = wake_tgt;
          end else begin
            st_d     = ST_STARTUP;
            tmr_load = 1'b1;
          end
        end
      end
      ST_STARTUP: begin
        if (tmr_done) st_d = vec_q ? ST_EXEC_NEXT : ST_RUN;
      end
      ST_EXEC_NEXT: st_d = ST_DUMMY;
      ST_DUMMY:     st_d = ST_RUN;
      default:      st_d = ST_RUN;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      pd_q  <= 1'b1;
      to_q  <= 1'b1;
      vec_q <= 1'b0;
      clr_q <= 1'b0;
      rsp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pd_q  <= pd_d;
      to_q  <= to_d;
      vec_q <= vec_d;
      clr_q <= clr_d;
      rsp_q <= rsp_d;
    end
  end

  // output decode
  assign tmr_run        = (st_q == ST_STARTUP);
  assign osc_enable     = (st_q != ST_SLEEP);
  assign core_halt      = (st_q == ST_SLEEP) || (st_q == ST_STARTUP);
  assign pd_bit         = pd_q;
  assign to_bit         = to_q;
  assign wdt_clear      = clr_q;
  assign dev_reset      = rsp_q;
  assign dummy_cycle    = (st_q == ST_DUMMY);
  assign redirect_valid = (st_q == ST_DUMMY);
  assign redirect_addr  = (st_q == ST_DUMMY) ? VEC : '0;

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && sleep_exec && !int_pending) |=>
      (st_q == ST_SLEEP && !pd_q && to_q && clr_q));

  // R4
  wdt_wake_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP && wake_src == WK_WDT) |=> (!to_q && clr_q));

  // R7
  dummy_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DUMMY) |-> $past(st_q == ST_EXEC_NEXT));

  // R9
  startup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STARTUP && !tmr_done) |=> (st_q == ST_STARTUP));

  // R12
  pd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_q |=> !pd_q);

  // R11
  sleep_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP && wake_src == WK_NONE) |=> (st_q == ST_SLEEP && !clr_q));

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int          N_SRC    = 4,
  parameter int          CNT_W    = 10,
  parameter int          ADDR_W   = 13,
  parameter logic [31:0] VEC_ADDR = 32'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_exec,
  input  logic              ext_reset_req,
  input  logic              wdt_timeout,
  input  logic              wdt_enable,
  input  logic [N_SRC-1:0]  int_flags,
  input  logic [N_SRC-1:0]  int_enables,
  input  logic              glob_int_en,
  input  logic              osc_is_rc,
  output logic              osc_enable,
  output logic              core_halt,
  output logic              pd_bit,
  output logic              to_bit,
  output logic              wdt_clear,
  output logic              dev_reset,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic              dummy_cycle
);

  logic      int_pending;
  wake_src_e wake_src;
  logic      tmr_load, tmr_run, tmr_done;

  swc_wake_detect #(.N_SRC(N_SRC)) u_detect (
    .ext_reset_req (ext_reset_req),
    .wdt_timeout   (wdt_timeout),
    .wdt_enable    (wdt_enable),
    .int_flags     (int_flags),
    .int_enables   (int_enables),
    .int_pending   (int_pending),
    .wake_src      (wake_src)
  );

  swc_startup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  swc_seq #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .sleep_exec     (sleep_exec),
    .wake_src       (wake_src),
    .int_pending    (int_pending),
    .glob_int_en    (glob_int_en),
    .osc_is_rc      (osc_is_rc),
    .tmr_done       (tmr_done),
    .tmr_load       (tmr_load),
    .tmr_run        (tmr_run),
    .osc_enable     (osc_enable),
    .core_halt      (core_halt),
    .pd_bit         (pd_bit),
    .to_bit         (to_bit),
    .wdt_clear      (wdt_clear),
    .dev_reset      (dev_reset),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr),
    .dummy_cycle    (dummy_cycle)
  );

  // R2
  osc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_enable |-> core_halt);

  // R3
  reset_clears_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> (wdt_clear && core_halt == !osc_is_rc));

  // R3
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> !dev_reset);

endmodule

// File: tb/tb_sleep_wake_ctrl.sv
module tb_sleep_wake_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int N_SRC  = 4;
  localparam int CNT_W  = 10;
  localparam int ADDR_W = 13;
  localparam int DELAY  = 1 << CNT_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sleep_exec, ext_reset_req, wdt_timeout, wdt_enable;
  logic [N_SRC-1:0]  int_flags, int_enables;
  logic              glob_int_en, osc_is_rc;
  logic              osc_enable, core_halt, pd_bit, to_bit, wdt_clear, dev_reset;
  logic              redirect_valid, dummy_cycle;
  logic [ADDR_W-1:0] redirect_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_wake_ctrl #(.N_SRC(N_SRC), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .ext_reset_req(ext_reset_req),
    .wdt_timeout(wdt_timeout), .wdt_enable(wdt_enable), .int_flags(int_flags),
    .int_enables(int_enables), .glob_int_en(glob_int_en), .osc_is_rc(osc_is_rc),
    .osc_enable(osc_enable), .core_halt(core_halt), .pd_bit(pd_bit), .to_bit(to_bit),
    .wdt_clear(wdt_clear), .dev_reset(dev_reset), .redirect_valid(redirect_valid),
    .redirect_addr(redirect_addr), .dummy_cycle(dummy_cycle)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    sleep_exec = 0; ext_reset_req = 0; wdt_timeout = 0;
    int_flags = '0; int_enables = '0; glob_int_en = 0;
  endtask

  task automatic enter_sleep();
    sleep_exec = 1; tick(); sleep_exec = 0;
  endtask

  // counts halted cycles starting at the current sample point
  task automatic count_halt(output int n);
    n = 0;
    while (core_halt && n < 5000) begin
      n++; tick();
    end
  endtask

  task automatic do_reset();
    quiet(); wdt_enable = 1; osc_is_rc = 0;
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "pd_bit", pd_bit, 1);
    chk("R1", "to_bit", to_bit, 1);
    chk("R1", "osc_enable", osc_enable, 1);
    chk("R1", "core_halt", core_halt, 0);
    chk("R1", "pulses", {wdt_clear, dev_reset, dummy_cycle, redirect_valid}, 0);
  endtask

  task automatic t_sleep_and_ignores();
    int n;
    enter_sleep();
    chk("R2", "pd_bit", pd_bit, 0);
    chk("R2", "to_bit", to_bit, 1);
    chk("R2", "osc_enable", osc_enable, 0);
    chk("R2", "core_halt", core_halt, 1);
    chk("R2", "wdt_clear", wdt_clear, 1);
    tick();
    chk("R2", "wdt_clear one cycle", wdt_clear, 0);
    // R11: second sleep strobe while asleep
    sleep_exec = 1; tick(); sleep_exec = 0;
    chk("R11", "wdt_clear", wdt_clear, 0);
    chk("R11", "osc_enable", osc_enable, 0);
    // R4: time-out with watchdog disabled
    wdt_enable = 0; wdt_timeout = 1; tick(); wdt_timeout = 0; wdt_enable = 1;
    chk("R4", "disabled wdt osc", osc_enable, 0);
    chk("R4", "disabled wdt to", to_bit, 1);
    // R5: flag without matching enable
    int_flags = 4'b0101; int_enables = 4'b1010; tick();
    chk("R5", "unmatched flag osc", osc_enable, 0);
    int_flags = '0; int_enables = '0;
    // R4: real watchdog wake
    wdt_timeout = 1; tick(); wdt_timeout = 0;
    chk("R4", "to cleared", to_bit, 0);
    chk("R4", "wdt_clear", wdt_clear, 1);
    chk("R4", "osc on", osc_enable, 1);
    chk("R3", "no dev_reset on wdt", dev_reset, 0);
    count_halt(n);
    chk("R9", "crystal halt cycles", n, DELAY);
    chk("R6", "no redirect", redirect_valid, 0);
    tick();
    chk("R6", "no dummy", dummy_cycle, 0);
    chk("R12", "pd stays 0", pd_bit, 0);
  endtask

  task automatic t_ext_wake();
    int n;
    enter_sleep();
    chk("R12", "to set again on sleep", to_bit, 1);
    ext_reset_req = 1; tick(); ext_reset_req = 0;
    chk("R3", "dev_reset", dev_reset, 1);
    chk("R3", "wdt_clear", wdt_clear, 1);
    chk("R3", "to", to_bit, 1);
    chk("R3", "pd", pd_bit, 0);
    tick();
    chk("R3", "dev_reset one cycle", dev_reset, 0);
    count_halt(n);
    chk("R9", "ext halt cycles", n, DELAY - 1);
    chk("R3", "no redirect", redirect_valid, 0);
  endtask

  task automatic t_int_wake(input bit gie);
    int n;
    enter_sleep();
    int_flags = 4'b1000; int_enables = 4'b1000; glob_int_en = gie; tick();
    int_flags = '0; int_enables = '0; glob_int_en = 0;
    chk("R5", "int wake osc", osc_enable, 1);
    chk("R5", "int wake wdt_clear", wdt_clear, 1);
    count_halt(n);
    chk("R9", "int halt cycles", n, DELAY);
    chk(gie ? "R7" : "R6", "first resume cycle redirect", redirect_valid, 0);
    tick();
    chk(gie ? "R7" : "R6", "dummy", dummy_cycle, gie);
    chk(gie ? "R7" : "R6", "redirect_valid", redirect_valid, gie);
    chk(gie ? "R7" : "R6", "redirect_addr", redirect_addr, gie ? 4 : 0);
    tick();
    chk(gie ? "R7" : "R6", "back to run", {dummy_cycle, redirect_valid, core_halt}, 0);
  endtask

  task automatic t_rc_mode();
    osc_is_rc = 1;
    enter_sleep();
    int_flags = 4'b0010; int_enables = 4'b0010; tick();
    int_flags = '0; int_enables = '0;
    chk("R9", "rc no delay halt", core_halt, 0);
    chk("R9", "rc osc", osc_enable, 1);
    osc_is_rc = 0;
  endtask

  task automatic t_priority();
    osc_is_rc = 1;
    enter_sleep();
    ext_reset_req = 1; wdt_timeout = 1; int_flags = 4'b1; int_enables = 4'b1;
    glob_int_en = 1; tick(); quiet();
    chk("R10", "ext wins dev_reset", dev_reset, 1);
    chk("R10", "ext wins to", to_bit, 1);
    enter_sleep();
    wdt_timeout = 1; int_flags = 4'b1; int_enables = 4'b1; glob_int_en = 1;
    tick(); quiet();
    chk("R10", "wdt over int to", to_bit, 0);
    chk("R10", "wdt over int no reset", dev_reset, 0);
    tick();
    chk("R10", "wdt over int no redirect", redirect_valid, 0);
    osc_is_rc = 0;
  endtask

  task automatic t_immediate(input bit gie);
    int_flags = 4'b0100; int_enables = 4'b0110; glob_int_en = gie;
    sleep_exec = 1;
    tick(); sleep_exec = 0; int_flags = '0; int_enables = '0; glob_int_en = 0;
    chk("R8", "pd", pd_bit, 0);
    chk("R8", "to", to_bit, 1);
    chk("R8", "osc stays on", osc_enable, 1);
    chk("R8", "no halt", core_halt, 0);
    chk("R8", "wdt_clear", wdt_clear, 1);
    chk("R8", "first cycle no redirect", redirect_valid, 0);
    tick();
    chk("R8", "redirect by gie", redirect_valid, gie);
    chk("R8", "dummy by gie", dummy_cycle, gie);
    tick();
  endtask

  task automatic t_pd_restore();
    do_reset();
    chk("R12", "pd restored by reset", pd_bit, 1);
  endtask

  initial begin
    rst_n = 0; quiet(); wdt_enable = 1; osc_is_rc = 0;
    t_reset();
    t_sleep_and_ignores();
    t_ext_wake();
    t_int_wake(1'b0);
    t_int_wake(1'b1);
    t_rc_mode();
    t_priority();
    t_immediate(1'b0);
    t_immediate(1'b1);
    t_pd_restore();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule